// File: doc/BRIEF.md
# Crystal-Clocked Service Watchdog

This block is a watchdog that runs from a 32.768 kHz crystal clock. A prescaler divides the clock by a parameter, 8192 by default, to make a 4 Hz tick with a 250 ms period. A 2-bit counter counts these ticks. If the host lets three ticks pass without servicing the watchdog, about 750 ms, the block raises its reset request output. The circuit that stretches this into a system reset pulse is outside the block.

The host services the watchdog by writing to the watchdog register address. The block sees that write as a strobe plus a decoded address-match line. A service write clears the prescaler, the tick counter and the reset request, so each full timeout is measured from the last service. An enable input gates the whole function. While it is low, every stage is held cleared and the reset request stays low. A synchronous power-on reset clears the block.

Top module: `wdt_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `wdt_reset` is 0, `tick_cnt` is 0 and `tick_pulse` is 0. `rst` clears an asserted reset request.
- R2: With `wd_en` high and no service write, `tick_pulse` is high for one cycle in every `PRESCALE_DIV` cycles. It is high during the last cycle of each division period, counted from the last clear.
- R3: Each tick raises `tick_cnt` by exactly one on the clock edge that ends the tick cycle.
- R4: `wdt_reset` rises on the same edge that takes `tick_cnt` to its terminal value 3. That edge is exactly 3×`PRESCALE_DIV` enabled, unserviced cycles after the last clear.
- R5: A service write is a cycle with `wr_stb` and `wr_addr_hit` both high while `wd_en` is high. On the next edge it clears `tick_cnt`, the prescaler phase and `wdt_reset`, and a new full timeout starts.
- R6: `wr_stb` without `wr_addr_hit`, or `wr_addr_hit` without `wr_stb`, has no effect on counting or on `wdt_reset`.
- R7: While `wd_en` is low, the prescaler and `tick_cnt` are held at 0 and `wdt_reset` is 0. When `wd_en` returns high, a full timeout is needed before the next assertion.
- R8: Once `wdt_reset` is high, it stays high until `rst`, a service write, or `wd_en` going low.
- R9: `tick_cnt` holds at 3 when further ticks arrive. It never wraps to 0 by counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz time-base clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wd_en | input | 1 | Watchdog enable bit |
| wr_stb | input | 1 | Host register write strobe |
| wr_addr_hit | input | 1 | Decoded match of the watchdog register address |
| wdt_reset | output | 1 | Reset request; high after a missed timeout |
| tick_pulse | output | 1 | One-cycle tick from the prescaler (4 Hz at default) |
| tick_cnt | output | TICK_W (2) | Current tick count |

## Verification
The hardest case to reach is a timeout that runs to its exact cycle after a service write lands in the middle of a prescaler period. The count must restart from that write, not from the earlier period boundary. With the default divider this needs tens of thousands of cycles per case. The bench therefore builds the block with a divider of 8. It services the block partway through a division period and then lets a full timeout expire, so the cycle where the reset request rises shows whether the prescaler phase was cleared. It also toggles the enable in the middle of a count. Partial address writes are sent while the reset request is already high, so that any effect they have would show at the ports.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned WDT_DEF_DIV = 8192;
    localparam int unsigned WDT_TICK_W  = 2;

    typedef enum logic [1:0] {
        WDT_HOLD_OFF = 2'd0,
        WDT_RESTART  = 2'd1,
        WDT_RUN      = 2'd2
    } wdt_mode_e;

    typedef struct packed {
        wdt_mode_e mode;
        logic      tick;
    } wdt_ctrl_t;

    function automatic wdt_mode_e wdt_pick_mode(input logic en, input logic stb, input logic hit);
        if (!en) begin
            return WDT_HOLD_OFF;
        end
        if (stb && hit) begin
            return WDT_RESTART;
        end
        return WDT_RUN;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int unsigned DIV = WDT_DEF_DIV
) (
    input  logic      clk,
    input  logic      rst,
    input  wdt_mode_e mode,
    output logic      tick
);
    localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (mode == WDT_RUN) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end else begin
            phase <= '0;
        end
    end

    assign tick = (mode == WDT_RUN) && (phase == LAST);

    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        tick |=> (phase == '0));
    a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST);
    a_r7_phase_idle: assert property (@(posedge clk) disable iff (rst)
        (mode == WDT_HOLD_OFF) |=> (phase == '0));
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
    import wdt_pkg::*;
#(
    parameter int unsigned TICK_W = WDT_TICK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wdt_ctrl_t         ctrl,
    output logic [TICK_W-1:0] cnt,
    output logic              near_term
);
    localparam logic [TICK_W-1:0] TERM = {TICK_W{1'b1}};
    localparam logic [TICK_W-1:0] PRE_TERM = TERM - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (ctrl.mode)
                WDT_RUN: begin
                    if (ctrl.tick && (cnt != TERM)) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign near_term = (cnt == PRE_TERM);

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == WDT_RUN && ctrl.tick && cnt != TERM) |=> (cnt == $past(cnt) + 1'b1));
    a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == WDT_RUN && cnt == TERM) |=> (cnt == TERM));
    a_r5_cnt_clear: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == WDT_RESTART) |=> (cnt == '0));
endmodule

// File: rtl/wdt_fire_flag.sv
module wdt_fire_flag
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wdt_ctrl_t ctrl,
    input  logic      near_term,
    output logic      fire
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fire <= 1'b0;
        end else if (ctrl.mode != WDT_RUN) begin
            fire <= 1'b0;
        end else if (ctrl.tick && near_term) begin
            fire <= 1'b1;
        end
    end

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (fire && ctrl.mode == WDT_RUN) |=> fire);
    a_r7_fire_low: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == WDT_HOLD_OFF) |=> !fire);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int unsigned PRESCALE_DIV = WDT_DEF_DIV,
    parameter int unsigned TICK_W       = WDT_TICK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wd_en,
    input  logic              wr_stb,
    input  logic              wr_addr_hit,
    output logic              wdt_reset,
    output logic              tick_pulse,
    output logic [TICK_W-1:0] tick_cnt
);
    localparam logic [TICK_W-1:0] TERM = {TICK_W{1'b1}};

    wdt_ctrl_t ctrl;
    logic      near_term;

    assign ctrl.mode = wdt_pick_mode(wd_en, wr_stb, wr_addr_hit);

    wdt_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .mode (ctrl.mode),
        .tick (ctrl.tick)
    );

    wdt_tick_counter #(.TICK_W(TICK_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .cnt       (tick_cnt),
        .near_term (near_term)
    );

    wdt_fire_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .near_term (near_term),
        .fire      (wdt_reset)
    );

    assign tick_pulse = ctrl.tick;

    // R4: the flag and the counter reach terminal together
    a_r4_fire_at_term: assert property (@(posedge clk) disable iff (rst)
        wdt_reset == (tick_cnt == TERM));
    a_r5_service: assert property (@(posedge clk) disable iff (rst)
        (wd_en && wr_stb && wr_addr_hit) |=> (!wdt_reset && tick_cnt == '0));
    a_r1_after_reset: assert property (@(posedge clk)
        rst |=> (!wdt_reset && tick_cnt == '0));
endmodule

// File: tb/wdt_top_tb.sv
module wdt_top_tb;
    localparam int D = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wd_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic       wr_addr_hit = 1'b0;
    logic       wdt_reset;
    logic       tick_pulse;
    logic [1:0] tick_cnt;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    int m_pre = 0;
    int m_cnt = 0;
    bit m_fire = 0;

    bit    q_fire[$];
    int    q_cnt[$];
    bit    q_tick[$];
    string q_tag[$];

    always #2 clk = ~clk;

    wdt_top #(.PRESCALE_DIV(D), .TICK_W(2)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .wd_en       (wd_en),
        .wr_stb      (wr_stb),
        .wr_addr_hit (wr_addr_hit),
        .wdt_reset   (wdt_reset),
        .tick_pulse  (tick_pulse),
        .tick_cnt    (tick_cnt)
    );

    // driver: apply one cycle of inputs and push the expected post-edge state
    task automatic step(input bit r, input bit en, input bit stb, input bit hit, input string tag);
        @(negedge clk);
        rst = r; wd_en = en; wr_stb = stb; wr_addr_hit = hit;
        if (r || !en || (stb && hit)) begin
            m_pre = 0; m_cnt = 0; m_fire = 0;
        end else if (m_pre == D - 1) begin
            m_pre = 0;
            if (m_cnt < 3) m_cnt = m_cnt + 1;
            if (m_cnt == 3) m_fire = 1;
        end else begin
            m_pre = m_pre + 1;
        end
        q_fire.push_back(m_fire);
        q_cnt.push_back(m_cnt);
        q_tick.push_back(en && !(stb && hit) && (m_pre == D - 1));
        q_tag.push_back(tag);
    endtask

    task automatic run(input int n, input bit en, input string tag);
        for (int i = 0; i < n; i++) step(0, en, 0, 0, tag);
    endtask

    // monitor: compare just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_tag.size() > 0) begin
                bit    ef;
                int    ec;
                bit    et;
                string tg;
                ef = q_fire.pop_front();
                ec = q_cnt.pop_front();
                et = q_tick.pop_front();
                tg = q_tag.pop_front();
                checks++;
                if (wdt_reset !== ef || int'(tick_cnt) != ec || tick_pulse !== et) begin
                    fails++;
                    $display("FAIL %s: reset=%0b cnt=%0d tick=%0b expected reset=%0b cnt=%0d tick=%0b",
                             tg, wdt_reset, tick_cnt, tick_pulse, ef, ec, et);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, reached %0d expected %0d", 20000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, "R1 reset");
        run(5, 0, "R7 disabled");
        run(3 * D - 1, 1, "R2 R3 count up");
        run(1, 1, "R4 timeout edge");
        run(2 * D + 3, 1, "R8 R9 hold");
        for (int i = 0; i < 3; i++) step(0, 1, 1, 0, "R6 strobe only");
        for (int i = 0; i < 3; i++) step(0, 1, 0, 1, "R6 addr only");
        step(0, 1, 1, 1, "R5 service");
        run(D + 3, 1, "R3 recount");
        step(0, 1, 1, 1, "R5 mid-period service");
        run(3 * D + 2, 1, "R4 R5 timeout from service");
        run(D + 2, 1, "R7 enable back");
        run(2, 0, "R7 enable low clears");
        run(2 * D + 1, 1, "R7 restart count");
        run(2, 0, "R7 mid-count disable");
        run(3 * D + 1, 1, "R4 full timeout after enable");
        step(1, 1, 0, 0, "R1 reset clears");
        run(2, 1, "R1 after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule